// File: doc/BRIEF.md
# Clock and Reset Bring-Up Sequencer

This block restarts a peripheral through a system-control interface that offers four separate one-cycle strobes. The strobes enable the clock, disable the clock, assert the reset and release the reset. Two one-bit status inputs report back to the block: whether the peripheral clock is running, and whether its reset is active.

A start pulse launches a fixed four-step handshake. The handshake first puts the peripheral into reset, then stops its clock, then releases the reset, and finally restarts the clock. After each strobe the block polls the matching status bit, once per cycle, until that bit reaches the level the step expects. A poll counter bounds each wait, and it is reloaded at the start of every step. The first step whose wait runs out ends the sequence at once. The block then pulses `done` together with a failure flag and a two-bit code that names the step that failed. When all four steps succeed, `done` pulses with the failure flag low.

The timeout is the parameter `TIMEOUT_POLLS`, so a simulation can use a short limit. Its default allows one million polls per step.

Top module: `clkrst_bringup`

## Requirements
- R1: Step code 0 emits one pulse on `rst_assert_stb` and then waits for `rst_active` to read 1.
- R2: Step code 1 emits one pulse on `clk_stop_stb` and then waits for `clk_running` to read 0.
- R3: Step code 2 emits one pulse on `rst_release_stb` and then waits for `rst_active` to read 0.
- R4: Step code 3 emits one pulse on `clk_start_stb` and then waits for `clk_running` to read 1.
- R5: At most one strobe is high in any cycle, and each strobe lasts one cycle. The first strobe comes in the cycle after the start pulse is sampled. Each later strobe comes in the cycle after the previous step's status poll matched.
- R6: The first poll of a step happens in the cycle after its strobe, and there is one poll per cycle. A step succeeds if the expected level is seen on any of its first `TIMEOUT_POLLS` polls, and fails after exactly `TIMEOUT_POLLS` polls that do not match.
- R7: When a step fails, `done` pulses for one cycle in the cycle after the last poll, with `fail` = 1 and `fail_step` equal to the failing step's code (0 to 3). No further strobe is issued.
- R8: When all four steps succeed, `done` pulses for one cycle in the cycle after the last matching poll, with `fail` = 0 and `fail_step` = 0.
- R9: A start pulse that arrives while `busy` is high is ignored. No strobe is repeated, and the timing of the run does not change.
- R10: While reset is held and in the first cycle after it, all strobes are low and `busy`, `done` and `fail` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to run the bring-up sequence |
| clk_running | input | 1 | Status: peripheral clock is running |
| rst_active | input | 1 | Status: peripheral reset is asserted |
| clk_start_stb | output | 1 | One-cycle clock-enable strobe |
| clk_stop_stb | output | 1 | One-cycle clock-disable strobe |
| rst_assert_stb | output | 1 | One-cycle reset-assert strobe |
| rst_release_stb | output | 1 | One-cycle reset-release strobe |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Valid with done: a step timed out |
| fail_step | output | 2 | Valid with done: code of the failed step |

## Verification
The bench replaces the system controller with a model. The model changes the matching status bit a chosen number of cycles after each strobe, and it can also be set never to respond. The sweep uses three kinds of answer for the steps that pass: an immediate answer, a one-cycle delay, and the last poll inside the limit. Together these separate off-by-one poll counting from correct counting. Every step is also made to fail in two ways: by an answer one poll too late, and by no answer at all. These runs show where the sequence stops, which code it reports, and that no later strobe leaks out. A stray start pulse is injected in the middle of every run, and the strobe order and the exact completion cycle must stay as predicted.

// File: rtl/clkrst_bringup_pkg.sv
package clkrst_bringup_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_t;

    // Step codes; the order is the behaviour of the sequence
    typedef enum logic [1:0] {
        STEP_RST_ON  = 2'd0,
        STEP_CLK_OFF = 2'd1,
        STEP_RST_OFF = 2'd2,
        STEP_CLK_ON  = 2'd3
    } step_t;

    localparam step_t LAST_STEP = STEP_CLK_ON;

    // Strobe vector bit positions
    localparam int STB_RST_ON  = 0;
    localparam int STB_CLK_OFF = 1;
    localparam int STB_RST_OFF = 2;
    localparam int STB_CLK_ON  = 3;
    localparam int NUM_STB     = 4;

    typedef struct packed {
        logic [NUM_STB-1:0] stb;     // strobe to fire in the issue cycle
        logic               watch_clk; // 1: poll clock status, 0: reset status
        logic               level;   // level that ends the wait
    } step_cfg_t;

    function automatic step_cfg_t step_cfg(input step_t s);
        step_cfg_t c;
        c = '0;
        unique case (s)
            STEP_RST_ON:  begin c.stb[STB_RST_ON]  = 1'b1; c.watch_clk = 1'b0; c.level = 1'b1; end
            STEP_CLK_OFF: begin c.stb[STB_CLK_OFF] = 1'b1; c.watch_clk = 1'b1; c.level = 1'b0; end
            STEP_RST_OFF: begin c.stb[STB_RST_OFF] = 1'b1; c.watch_clk = 1'b0; c.level = 1'b0; end
            STEP_CLK_ON:  begin c.stb[STB_CLK_ON]  = 1'b1; c.watch_clk = 1'b1; c.level = 1'b1; end
            default:      c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/clkrst_step_decode.sv
module clkrst_step_decode
    import clkrst_bringup_pkg::*;
(
    input  step_t              step,
    input  logic               issue,
    input  logic               clk_running,
    input  logic               rst_active,
    output logic [NUM_STB-1:0] stb,
    output logic               hit
);
    step_cfg_t cfg;
    logic      sel;

    always_comb begin
        cfg = step_cfg(step);
        sel = cfg.watch_clk ? clk_running : rst_active;
        hit = (sel == cfg.level);
        stb = issue ? cfg.stb : '0;
    end
endmodule

// File: rtl/clkrst_poll_timer.sv
module clkrst_poll_timer #(
    parameter int LIMIT = 1000000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic poll,
    output logic last
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [CW-1:0] LAST_IDX = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || load) begin
            cnt_q <= '0;
        end else if (poll && cnt_q != LAST_IDX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // the poll made in this cycle is the final one allowed
    assign last = (cnt_q == LAST_IDX);
endmodule

// File: rtl/clkrst_bringup.sv
module clkrst_bringup
    import clkrst_bringup_pkg::*;
#(
    parameter int TIMEOUT_POLLS = 1000000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       clk_running,
    input  logic       rst_active,
    output logic       clk_start_stb,
    output logic       clk_stop_stb,
    output logic       rst_assert_stb,
    output logic       rst_release_stb,
    output logic       busy,
    output logic       done,
    output logic       fail,
    output logic [1:0] fail_step
);
    seq_state_t         state_q;
    step_t              step_q;
    logic               done_q, fail_q;
    logic [1:0]         code_q;
    logic [NUM_STB-1:0] stb;
    logic               hit, last_poll;

    clkrst_step_decode u_dec (
        .step        (step_q),
        .issue       (state_q == ST_ISSUE),
        .clk_running (clk_running),
        .rst_active  (rst_active),
        .stb         (stb),
        .hit         (hit)
    );

    clkrst_poll_timer #(.LIMIT(TIMEOUT_POLLS)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .load (state_q == ST_ISSUE),
        .poll (state_q == ST_WAIT),
        .last (last_poll)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            step_q  <= STEP_RST_ON;
            done_q  <= 1'b0;
            fail_q  <= 1'b0;
            code_q  <= '0;
        end else begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
            code_q <= '0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        step_q  <= STEP_RST_ON;
                        state_q <= ST_ISSUE;
                    end
                end
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (hit) begin
                        if (step_q == LAST_STEP) begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            step_q  <= step_t'(step_q + 2'd1);
                            state_q <= ST_ISSUE;
                        end
                    end else if (last_poll) begin
                        done_q  <= 1'b1;
                        fail_q  <= 1'b1;
                        code_q  <= step_q;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rst_assert_stb  = stb[STB_RST_ON];
    assign clk_stop_stb    = stb[STB_CLK_OFF];
    assign rst_release_stb = stb[STB_RST_OFF];
    assign clk_start_stb   = stb[STB_CLK_ON];
    assign busy            = (state_q != ST_IDLE);
    assign done            = done_q;
    assign fail            = fail_q;
    assign fail_step       = code_q;
endmodule

// File: rtl/clkrst_bringup_chk.sv
module clkrst_bringup_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       clk_running,
    input logic       rst_active,
    input logic       clk_start_stb,
    input logic       clk_stop_stb,
    input logic       rst_assert_stb,
    input logic       rst_release_stb,
    input logic       busy,
    input logic       done,
    input logic       fail,
    input logic [1:0] fail_step
);
    logic any_stb;
    assign any_stb = clk_start_stb | clk_stop_stb | rst_assert_stb | rst_release_stb;

    // R5
    stb_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({clk_start_stb, clk_stop_stb, rst_assert_stb, rst_release_stb}));

    // R5
    stb_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        any_stb |=> !any_stb);

    // R9
    seq_begin_chk: assert property (@(posedge clk) disable iff (rst)
        rst_assert_stb |-> ($past(start) && !$past(busy)));

    // R2
    clk_off_after_rst_on_chk: assert property (@(posedge clk) disable iff (rst)
        clk_stop_stb |-> $past(rst_active));

    // R3
    rst_off_after_clk_off_chk: assert property (@(posedge clk) disable iff (rst)
        rst_release_stb |-> !$past(clk_running));

    // R4
    clk_on_after_rst_off_chk: assert property (@(posedge clk) disable iff (rst)
        clk_start_stb |-> !$past(rst_active));

    // R8
    pass_clk_running_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !fail) |-> ($past(clk_running) && fail_step == 2'd0));

    // R7
    fail_only_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        fail |-> done);

    // R7
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !any_stb));
endmodule

bind clkrst_bringup clkrst_bringup_chk u_chk (.*);

// File: tb/clkrst_bringup_test.sv
module clkrst_bringup_test;
    localparam int T = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic clk_running, rst_active;
    logic clk_start_stb, clk_stop_stb, rst_assert_stb, rst_release_stb;
    logic busy, done, fail;
    logic [1:0] fail_step;

    always #2.5 clk = ~clk;

    clkrst_bringup #(.TIMEOUT_POLLS(T)) uut (
        .clk(clk), .rst(rst), .start(start),
        .clk_running(clk_running), .rst_active(rst_active),
        .clk_start_stb(clk_start_stb), .clk_stop_stb(clk_stop_stb),
        .rst_assert_stb(rst_assert_stb), .rst_release_stb(rst_release_stb),
        .busy(busy), .done(done), .fail(fail), .fail_step(fail_step)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // controller model: per-step answer delay, value >= 50 means never
    int lat [4];
    int pend_r = 0, pend_c = 0;
    logic tgt_r, tgt_c;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            clk_running <= 1'b1; rst_active <= 1'b0;
            pend_r <= 0; pend_c <= 0;
        end else begin
            if (rst_assert_stb || rst_release_stb) begin
                int l;
                l = rst_assert_stb ? lat[0] : lat[2];
                tgt_r <= rst_assert_stb;
                if (l == 0) rst_active <= rst_assert_stb;
                else if (l < 50) pend_r <= l;
            end else if (pend_r != 0) begin
                pend_r <= pend_r - 1;
                if (pend_r == 1) rst_active <= tgt_r;
            end
            if (clk_start_stb || clk_stop_stb) begin
                int l;
                l = clk_stop_stb ? lat[1] : lat[3];
                tgt_c <= clk_start_stb;
                if (l == 0) clk_running <= clk_start_stb;
                else if (l < 50) pend_c <= l;
            end else if (pend_c != 0) begin
                pend_c <= pend_c - 1;
                if (pend_c == 1) clk_running <= tgt_c;
            end
        end
    end

    // strobe log sampled away from the edge
    int slog [16];
    int sn = 0;
    always @(negedge clk) begin
        if (!rst && sn < 16) begin
            if (rst_assert_stb)  begin slog[sn] = 0; sn = sn + 1; end
            if (clk_stop_stb)    begin slog[sn] = 1; sn = sn + 1; end
            if (rst_release_stb) begin slog[sn] = 2; sn = sn + 1; end
            if (clk_start_stb)   begin slog[sn] = 3; sn = sn + 1; end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; start = 1'b0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        sn = 0;
    endtask

    task automatic run(input int l0, input int l1, input int l2, input int l3);
        int n, exp_n, last, fstep, polls;
        bit failed;
        lat[0] = l0; lat[1] = l1; lat[2] = l2; lat[3] = l3;
        do_reset();
        exp_n = 1; failed = 0; last = 3; fstep = 0;
        for (int i = 0; i < 4; i++) begin
            if (!failed) begin
                if (lat[i] < T) polls = lat[i] + 1;
                else begin polls = T; failed = 1; last = i; fstep = i; end
                exp_n += 1 + polls;
            end
        end
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        n = 1;
        while (!done && n < 200) begin
            @(negedge clk); n++;
            // R9: stray start while the sequence runs
            start = (n == 3);
        end
        start = 1'b0;
        check(failed ? "R6 R7 done cycle" : "R6 R8 done cycle", n, exp_n);
        check(failed ? "R7 fail flag" : "R8 fail flag", int'(fail), int'(failed));
        check(failed ? "R7 fail_step" : "R8 fail_step", int'(fail_step), fstep);
        @(negedge clk);
        check("R7 done one cycle", int'(done), 0);
        repeat (3) @(negedge clk);
        check("R5 R9 strobe count", sn, last + 1);
        for (int i = 0; i <= last; i++) begin
            if (i == 0) check("R1 strobe order", slog[i], 0);
            if (i == 1) check("R2 strobe order", slog[i], 1);
            if (i == 2) check("R3 strobe order", slog[i], 2);
            if (i == 3) check("R4 strobe order", slog[i], 3);
        end
    endtask

    initial begin
        int pat [3];
        pat[0] = 0; pat[1] = 1; pat[2] = T - 1;
        // R10 reset state
        lat[0] = 0; lat[1] = 0; lat[2] = 0; lat[3] = 0;
        @(negedge clk);
        check("R10 strobes in reset",
              int'({clk_start_stb, clk_stop_stb, rst_assert_stb, rst_release_stb}), 0);
        check("R10 busy/done/fail in reset", int'({busy, done, fail}), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R10 idle after reset", int'({busy, done, fail}), 0);
        for (int fs = 0; fs <= 4; fs++) begin
            for (int lv = 0; lv < 3; lv++) begin
                for (int fm = 0; fm < 2; fm++) begin
                    if (!(fs == 4 && fm == 1)) begin
                        int l [4];
                        for (int i = 0; i < 4; i++) begin
                            l[i] = pat[(i + lv) % 3];
                            if (i == fs) l[i] = (fm == 0) ? T : 99;
                        end
                        run(l[0], l[1], l[2], l[3]);
                    end
                end
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected 0", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule